// File: doc/BRIEF.md
# Periodic Event Generator with Interrupt Flag

This block turns one of four timebase sources into a periodic event. It signals the event on an active-low strobe output and on a status flag that software can read and clear. The sources are a 64 Hz tap and a 1 Hz tap from the sub-second prescaler, plus the carry pulses that the calendar counter produces at each minute and each hour. A two-bit rate field picks the source. A mode bit picks between latched-interrupt behaviour and self-ending pulse behaviour. A mask bit silences the block.

In interrupt mode, every selected event sets the flag. The flag stays set until software writes a zero to it, and the strobe output stays low for the whole time the flag is held. In pulse mode, the flag follows a short pulse. The pulse begins at the event and ends at the next 128 Hz prescaler tick, which gives a width of about 7.8 ms at every rate. Software can end the pulse early by writing a zero. A write of one has no effect in either mode. The host bus decode is outside this block and supplies a single write strobe together with the written data bit.

Top module: `periodic_event_gen`

## Requirements
- R1: `rate_sel` selects the event source. 0 selects `tap_64hz`, 1 selects `tap_1hz`, 2 selects `carry_min` and 3 selects `carry_hour`. A strobe on a source that is not selected never sets the flag.
- R2: While `mask` is 1, no event sets `irq_flag`, and `std_n` is 1 whatever the flag holds.
- R3: In interrupt mode (`irq_mode`=1), a selected, unmasked event sets `irq_flag` on the next clock edge. The flag then stays 1, and `tick_128hz` does not clear it.
- R4: A write (`flag_wr`=1) with `flag_wdata`=0 clears `irq_flag` on the next edge. A write with `flag_wdata`=1 leaves the flag unchanged.
- R5: `std_n` is 0 exactly when `irq_flag` is 1 and `mask` is 0. It has no register stage, so it follows `irq_flag` and `mask` in the same cycle.
- R6: In pulse mode (`irq_mode`=0), a selected, unmasked event sets `irq_flag` on the next edge. The flag then clears on the edge that follows the first `tick_128hz` strobe.
- R7: In pulse mode, writing 0 to the flag while a pulse is active ends the pulse on the next edge.
- R8: An event in the same cycle as a clearing write, or as a `tick_128hz` strobe, wins: the flag is 1 after that edge.
- R9: While `rst_n` is 0 at a clock edge, `irq_flag` becomes 0 and `std_n` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tap_64hz | input | 1 | One-cycle strobe every 1/64 s |
| tap_1hz | input | 1 | One-cycle strobe every second |
| carry_min | input | 1 | One-cycle carry at each minute rollover |
| carry_hour | input | 1 | One-cycle carry at each hour rollover |
| tick_128hz | input | 1 | One-cycle strobe every 1/128 s; ends a pulse |
| rate_sel | input | 2 | Event source select (see R1) |
| irq_mode | input | 1 | 1 = latched interrupt, 0 = self-ending pulse |
| mask | input | 1 | 1 = suppress events and hold `std_n` high |
| flag_wr | input | 1 | Write strobe for the flag |
| flag_wdata | input | 1 | Data bit written to the flag |
| std_n | output | 1 | Active-low periodic strobe output |
| irq_flag | output | 1 | Flag status as software reads it |

## Verification
A new event can land in the same cycle as something that clears the flag. In interrupt mode, the clearing source is a software write of zero. In pulse mode, it is either that write or the 128 Hz tick that ends the pulse. The bench provokes both cases by driving a selected source strobe in the same cycle as a zero write, and in a separate cycle alongside `tick_128hz`. It judges the result by the flag and `std_n` after the edge: both must show the new event as active, and the pulse must then end on the next 128 Hz tick.

// File: rtl/fpg_pkg.sv
// Shared definitions for the periodic event generator.
// Assumes: the four sources are ordered fastest to slowest; the order is the
// rate_sel encoding that software programs.
package fpg_pkg;

    localparam int NUM_RATES = 4;
    localparam int RATE_W    = $clog2(NUM_RATES);

    typedef enum logic [RATE_W-1:0] {
        RATE_64HZ = 2'd0,
        RATE_1S   = 2'd1,
        RATE_1MIN = 2'd2,
        RATE_1H   = 2'd3
    } rate_e;

endpackage

// File: rtl/fpg_tap_select.sv
// Picks one strobe out of NUM_TAPS timebase sources.
// Assumes: every tap is a single-cycle strobe in the clk domain; sel is static
// or changes only between strobes.
module fpg_tap_select #(
    parameter int NUM_TAPS = fpg_pkg::NUM_RATES,
    parameter int SEL_W    = $clog2(NUM_TAPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TAPS-1:0] taps,
    input  logic [SEL_W-1:0]    sel,
    output logic                evt
);

    logic [NUM_TAPS-1:0] hit;

    // One decode gate per source: a source passes only when it is selected.
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        assign hit[g] = taps[g] && (sel == SEL_W'(g));
    end

    // Merge the decoded sources into one event strobe.
    assign evt = |hit;

    // R1: at most one source can pass the decode at a time.
    p_single_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: rtl/fpg_flag_ctrl.sv
// Holds the flag bit shared by interrupt mode and pulse mode.
// Assumes: evt is already gated by the mask; clr_wr is the decoded "write 0"
// strobe; end_tick is the 1/128 s prescaler strobe.
module fpg_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic irq_mode,
    input  logic clr_wr,
    input  logic end_tick,
    output logic flag_q
);

    logic flag_d;

    // Next-state: a new event wins over any clearing source.
    always_comb begin
        if (evt) begin
            flag_d = 1'b1;
        end else if (clr_wr) begin
            flag_d = 1'b0;
        end else if (!irq_mode && end_tick) begin
            flag_d = 1'b0;
        end else begin
            flag_d = flag_q;
        end
    end

    // Flag register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    // R3 / R6: an event sets the flag one edge later.
    p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag_q);
    // R4 / R7: a write of zero without a competing event clears the flag.
    p_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !evt) |=> !flag_q);
    // R6: in pulse mode the 128 Hz tick ends the pulse.
    p_pulse_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_mode && end_tick && !evt) |=> !flag_q);
    // R3: in interrupt mode only a write of zero can drop a set flag.
    p_latch_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode && flag_q && !clr_wr) |=> flag_q);
    // R8: the flag never rises without an event one cycle earlier.
    p_rise_needs_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(evt));

endmodule

// File: rtl/fpg_std_drive.sv
// Forms the active-low strobe output from the flag and the mask.
// Assumes: no register stage is wanted; the output follows the flag in the
// same cycle.
module fpg_std_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    input  logic mask,
    output logic std_n
);

    // Drive low only while the flag is set and the output is not masked.
    assign std_n = !(flag && !mask);

    // R2: a masked output stays high.
    p_mask_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> std_n);
    // R5: the output is low whenever an unmasked flag is set.
    p_follow_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !mask) |-> !std_n);

endmodule

// File: rtl/periodic_event_gen.sv
// Periodic event generator: selects a timebase source, gates it with the mask,
// keeps the software-visible flag and drives the active-low strobe.
// Assumes: all inputs are synchronous to clk; the bus decode outside supplies
// flag_wr for one cycle per write.
module periodic_event_gen
    import fpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tap_64hz,
    input  logic              tap_1hz,
    input  logic              carry_min,
    input  logic              carry_hour,
    input  logic              tick_128hz,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              irq_mode,
    input  logic              mask,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    output logic              std_n,
    output logic              irq_flag
);

    logic [NUM_RATES-1:0] taps;
    logic                 sel_evt;
    logic                 evt;
    logic                 clr_wr;

    // Source order matches the rate_e encoding.
    assign taps[RATE_64HZ] = tap_64hz;
    assign taps[RATE_1S]   = tap_1hz;
    assign taps[RATE_1MIN] = carry_min;
    assign taps[RATE_1H]   = carry_hour;

    fpg_tap_select #(
        .NUM_TAPS (NUM_RATES),
        .SEL_W    (RATE_W)
    ) i_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (taps),
        .sel   (rate_sel),
        .evt   (sel_evt)
    );

    // Mask gate and write decode; a write of one is dropped here.
    assign evt    = sel_evt && !mask;
    assign clr_wr = flag_wr && !flag_wdata;

    fpg_flag_ctrl i_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .irq_mode (irq_mode),
        .clr_wr   (clr_wr),
        .end_tick (tick_128hz),
        .flag_q   (irq_flag)
    );

    fpg_std_drive i_std (
        .clk   (clk),
        .rst_n (rst_n),
        .flag  (irq_flag),
        .mask  (mask),
        .std_n (std_n)
    );

    // R2: with the mask set, a clear flag stays clear.
    p_mask_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && !irq_flag) |=> !irq_flag);
    // R4: a write of one never clears the flag.
    p_write_one_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && flag_wdata && irq_flag && irq_mode) |=> irq_flag);

endmodule

// File: tb/test_periodic_event_gen.sv
`timescale 1ns/1ps
module test_periodic_event_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] taps;
    logic       tick_128hz;
    logic [1:0] rate_sel;
    logic       irq_mode;
    logic       mask;
    logic       flag_wr;
    logic       flag_wdata;
    logic       std_n;
    logic       irq_flag;
    int         checks = 0;
    int         errors = 0;
    bit         done   = 1'b0;

    always #4 clk = ~clk;

    periodic_event_gen i_periodic_event_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .tap_64hz   (taps[0]),
        .tap_1hz    (taps[1]),
        .carry_min  (taps[2]),
        .carry_hour (taps[3]),
        .tick_128hz (tick_128hz),
        .rate_sel   (rate_sel),
        .irq_mode   (irq_mode),
        .mask       (mask),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .std_n      (std_n),
        .irq_flag   (irq_flag)
    );

    // Row: mode, mask, sel[1:0], taps{hour,min,1hz,64hz}, tick128, wr, wdata,
    //      expected flag, expected std_n (sampled after the edge).
    localparam int NV = 26;
    localparam logic [12:0] VT [0:NV-1] = '{
        {1'b1,1'b0,2'd0,4'b0000,1'b0,1'b0,1'b0, 1'b0,1'b1}, // R1 idle
        {1'b1,1'b0,2'd0,4'b0010,1'b0,1'b0,1'b0, 1'b0,1'b1}, // R1 unselected 1 Hz
        {1'b1,1'b0,2'd0,4'b0001,1'b0,1'b0,1'b0, 1'b1,1'b0}, // R3 set by 64 Hz
        {1'b1,1'b0,2'd0,4'b0000,1'b0,1'b0,1'b0, 1'b1,1'b0}, // R3 hold
        {1'b1,1'b0,2'd0,4'b0000,1'b0,1'b1,1'b1, 1'b1,1'b0}, // R4 write 1
        {1'b1,1'b0,2'd0,4'b0000,1'b0,1'b1,1'b0, 1'b0,1'b1}, // R4 write 0
        {1'b1,1'b0,2'd1,4'b0001,1'b0,1'b0,1'b0, 1'b0,1'b1}, // R1 unselected 64 Hz
        {1'b1,1'b0,2'd1,4'b0010,1'b0,1'b0,1'b0, 1'b1,1'b0}, // R1 1 Hz
        {1'b1,1'b1,2'd1,4'b0000,1'b0,1'b0,1'b0, 1'b1,1'b1}, // R2 / R5 masked high
        {1'b1,1'b0,2'd1,4'b0000,1'b0,1'b1,1'b0, 1'b0,1'b1}, // R4 clear
        {1'b1,1'b1,2'd2,4'b0100,1'b0,1'b0,1'b0, 1'b0,1'b1}, // R2 masked event
        {1'b1,1'b0,2'd2,4'b0100,1'b0,1'b1,1'b0, 1'b1,1'b0}, // R8 event vs write 0
        {1'b1,1'b0,2'd2,4'b0000,1'b0,1'b1,1'b0, 1'b0,1'b1}, // R4 clear
        {1'b1,1'b0,2'd3,4'b0100,1'b0,1'b0,1'b0, 1'b0,1'b1}, // R1 unselected minute
        {1'b1,1'b0,2'd3,4'b1000,1'b0,1'b0,1'b0, 1'b1,1'b0}, // R1 hour
        {1'b1,1'b0,2'd3,4'b0000,1'b1,1'b0,1'b0, 1'b1,1'b0}, // R3 tick ignored
        {1'b1,1'b0,2'd3,4'b0000,1'b0,1'b1,1'b0, 1'b0,1'b1}, // R4 clear
        {1'b0,1'b0,2'd0,4'b0001,1'b0,1'b0,1'b0, 1'b1,1'b0}, // R6 pulse start
        {1'b0,1'b0,2'd0,4'b0000,1'b0,1'b0,1'b0, 1'b1,1'b0}, // R6 / R5 active
        {1'b0,1'b0,2'd0,4'b0000,1'b1,1'b0,1'b0, 1'b0,1'b1}, // R6 tick ends
        {1'b0,1'b0,2'd0,4'b0001,1'b0,1'b0,1'b0, 1'b1,1'b0}, // R6 pulse start
        {1'b0,1'b0,2'd0,4'b0000,1'b0,1'b1,1'b1, 1'b1,1'b0}, // R4 write 1 in pulse
        {1'b0,1'b0,2'd0,4'b0000,1'b0,1'b1,1'b0, 1'b0,1'b1}, // R7 cancel
        {1'b0,1'b0,2'd0,4'b0001,1'b1,1'b0,1'b0, 1'b1,1'b0}, // R8 event vs tick
        {1'b0,1'b0,2'd0,4'b0000,1'b1,1'b0,1'b0, 1'b0,1'b1}, // R6 tick ends
        {1'b0,1'b1,2'd0,4'b0001,1'b0,1'b0,1'b0, 1'b0,1'b1}  // R2 masked pulse
    };

    task automatic check(input string tag, input logic f_exp, input logic s_exp);
        checks += 2;
        if (irq_flag !== f_exp) begin
            errors++;
            $display("FAIL %s irq_flag actual %b expected %b", tag, irq_flag, f_exp);
        end
        if (std_n !== s_exp) begin
            errors++;
            $display("FAIL %s std_n actual %b expected %b", tag, std_n, s_exp);
        end
    endtask

    task automatic idle_inputs();
        taps = '0; tick_128hz = 0; flag_wr = 0; flag_wdata = 0;
    endtask

    initial begin
        rst_n = 0; idle_inputs(); rate_sel = 0; irq_mode = 1; mask = 0;
        repeat (3) @(negedge clk);
        check("R9 reset", 1'b0, 1'b1);
        rst_n = 1;
        for (int i = 0; i < NV; i++) begin
            irq_mode   = VT[i][12];
            mask       = VT[i][11];
            rate_sel   = VT[i][10:9];
            taps       = VT[i][8:5];
            tick_128hz = VT[i][4];
            flag_wr    = VT[i][3];
            flag_wdata = VT[i][2];
            @(negedge clk);
            check($sformatf("vector %0d", i), VT[i][1], VT[i][0]);
        end
        // R9: reset while a latched flag is held.
        idle_inputs(); irq_mode = 1; mask = 0; rate_sel = 2'd1; taps = 4'b0010;
        @(negedge clk);
        check("R3 preset", 1'b1, 1'b0);
        idle_inputs(); rst_n = 0;
        @(negedge clk);
        check("R9 reset clears", 1'b0, 1'b1);
        rst_n = 1;
        // R5: unmasking an already set flag drives std_n low in the same cycle.
        taps = 4'b0010;
        @(negedge clk);
        idle_inputs(); mask = 1;
        #1 check("R5 masked", 1'b1, 1'b1);
        mask = 0;
        #1 check("R5 unmasked", 1'b1, 1'b0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule